// File: doc/BRIEF.md
# Paged Effective Address Generator

This block owns the memory address register of a small 12-bit processor. During the address step of an instruction fetch it forms the direct operand address of a memory-reference instruction and loads it into the register. The low seven address bits are always the offset field of the instruction word. The upper five bits are either zero or the current page of the program counter, and one instruction bit picks which.

The same register has three other load points, each driven by a one-cycle step strobe from the sequencer:

- a load of the program counter at the start of fetch;
- a load from the operator console switches;
- an increment.

When more than one strobe is high in a cycle, a fixed priority decides which one acts. When no strobe is high, the register keeps its value. The output comes straight from a flop.

Top module: `pg_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `mar` becomes 0000 (octal).
- R2: With `stb_ea` high and `ld_panel` low, if instruction bit 7 (octal weight 0200) is 0, `mar` becomes zero in bits 11..7 and `instr_word[6:0]` in bits 6..0 after the edge. For example, 7042 gives 0042 for any program counter value.
- R3: Under the same strobes, if instruction bit 7 is 1, `mar` becomes `prog_ctr[11:7]` followed by `instr_word[6:0]`. For example, 7242 with PC 7777 gives 7642, and with PC 1234 gives 1242.
- R4: Instruction bits 11..8 have no effect on the address formed in R2 or R3.
- R5: With `stb_pc` high and both `ld_panel` and `stb_ea` low, `mar` takes the value of `prog_ctr`.
- R6: With `ld_panel` high, `mar` takes the value of `panel_sw`, whatever the other strobes are.
- R7: With `stb_inc` as the only strobe high, `mar` increments by one modulo 4096, so 7777 becomes 0000.
- R8: With no strobe high, `mar` holds its value.
- R9: The strobes are served in the order `ld_panel`, then `stb_ea`, then `stb_pc`, then `stb_inc`. Only the highest active source loads the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 12 | Instruction register contents |
| prog_ctr | input | 12 | Program counter contents |
| panel_sw | input | 12 | Console switch value |
| ld_panel | input | 1 | Console load strobe |
| stb_ea | input | 1 | Address-forming step strobe |
| stb_pc | input | 1 | Fetch-start step strobe (PC to address register) |
| stb_inc | input | 1 | Address increment strobe |
| mar | output | 12 | Memory address register |

## Verification
The assertions check on every cycle the value that each strobe combination puts into the register: the zero-page and current-page forms, the PC and console loads, the increment and the hold. The priority rules are written into each assertion's antecedent.

Only the bench scenarios can show the specific cases. These are the fixed address of 7042 for widely different PC values, the insensitivity to the opcode bits, the wrap of the increment from 7777 to 0000, and the result when several strobes collide.

// File: rtl/pgea_pkg.sv
package pgea_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD  = 3'd0,
    SRC_INC   = 3'd1,
    SRC_PC    = 3'd2,
    SRC_EA    = 3'd3,
    SRC_PANEL = 3'd4
  } mar_src_e;
endpackage

// File: rtl/pgea_ea_calc.sv
module pgea_ea_calc #(
  parameter int WORD_W = 12,
  parameter int OFF_W  = 7
) (
  input  logic [OFF_W:0]      ir_low,
  input  logic [WORD_W-1:0]   pc,
  output logic [WORD_W-1:0]   ea
);
  localparam int PAGE_W = WORD_W - OFF_W;

  logic cur_page;
  assign cur_page = ir_low[OFF_W];

  // Offset field passes straight through.
  assign ea[OFF_W-1:0] = ir_low[OFF_W-1:0];

  // Each page bit is either zero or the matching PC bit.
  for (genvar i = 0; i < PAGE_W; i++) begin : g_page
    assign ea[OFF_W+i] = cur_page & pc[OFF_W+i];
  end
endmodule

// File: rtl/pgea_src_sel.sv
module pgea_src_sel
  import pgea_pkg::*;
(
  input  logic     ld_panel,
  input  logic     stb_ea,
  input  logic     stb_pc,
  input  logic     stb_inc,
  output mar_src_e src
);
  always_comb begin
    if (ld_panel)     src = SRC_PANEL;
    else if (stb_ea)  src = SRC_EA;
    else if (stb_pc)  src = SRC_PC;
    else if (stb_inc) src = SRC_INC;
    else              src = SRC_HOLD;
  end
endmodule

// File: rtl/pgea_mar_reg.sv
module pgea_mar_reg
  import pgea_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  mar_src_e          src,
  input  logic [WORD_W-1:0] panel_val,
  input  logic [WORD_W-1:0] ea_val,
  input  logic [WORD_W-1:0] pc_val,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] d;

  always_comb begin
    unique case (src)
      SRC_PANEL: d = panel_val;
      SRC_EA:    d = ea_val;
      SRC_PC:    d = pc_val;
      SRC_INC:   d = q + WORD_W'(1);
      default:   d = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/pg_addr_gen.sv
module pg_addr_gen
  import pgea_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [WORD_W-1:0] prog_ctr,
  input  logic [WORD_W-1:0] panel_sw,
  input  logic              ld_panel,
  input  logic              stb_ea,
  input  logic              stb_pc,
  input  logic              stb_inc,
  output logic [WORD_W-1:0] mar
);
  localparam int OP_W = WORD_W - OFF_W - 1;

  logic [WORD_W-1:0] ea_val;
  mar_src_e          src;
  logic [OP_W-1:0]   unused_opcode;

  // Opcode bits play no part in address formation.
  assign unused_opcode = instr_word[WORD_W-1:OFF_W+1];

  pgea_ea_calc #(.WORD_W(WORD_W), .OFF_W(OFF_W)) ea_i (
    .ir_low (instr_word[OFF_W:0]),
    .pc     (prog_ctr),
    .ea     (ea_val)
  );

  pgea_src_sel sel_i (
    .ld_panel (ld_panel),
    .stb_ea   (stb_ea),
    .stb_pc   (stb_pc),
    .stb_inc  (stb_inc),
    .src      (src)
  );

  pgea_mar_reg #(.WORD_W(WORD_W)) reg_i (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .panel_val (panel_sw),
    .ea_val    (ea_val),
    .pc_val    (prog_ctr),
    .q         (mar)
  );
endmodule

// File: rtl/pgea_checker.sv
module pgea_checker #(
  parameter int WORD_W = 12,
  parameter int OFF_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] instr_word,
  input logic [WORD_W-1:0] prog_ctr,
  input logic [WORD_W-1:0] panel_sw,
  input logic              ld_panel,
  input logic              stb_ea,
  input logic              stb_pc,
  input logic              stb_inc,
  input logic [WORD_W-1:0] mar
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> mar == '0); // R1

  AST_EA_ZERO_PAGE: assert property (@(posedge clk) disable iff (rst)
    (stb_ea && !ld_panel && !instr_word[OFF_W]) |=>
      (mar[WORD_W-1:OFF_W] == '0) &&
      (mar[OFF_W-1:0] == $past(instr_word[OFF_W-1:0]))); // R2

  AST_EA_CUR_PAGE: assert property (@(posedge clk) disable iff (rst)
    (stb_ea && !ld_panel && instr_word[OFF_W]) |=>
      (mar[WORD_W-1:OFF_W] == $past(prog_ctr[WORD_W-1:OFF_W])) &&
      (mar[OFF_W-1:0] == $past(instr_word[OFF_W-1:0]))); // R3

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (stb_pc && !stb_ea && !ld_panel) |=> mar == $past(prog_ctr)); // R5

  AST_PANEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_panel |=> mar == $past(panel_sw)); // R6

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (stb_inc && !stb_pc && !stb_ea && !ld_panel) |=>
      mar == WORD_W'($past(mar) + WORD_W'(1))); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!stb_inc && !stb_pc && !stb_ea && !ld_panel) |=> $stable(mar)); // R8

  AST_PANEL_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld_panel && (stb_ea || stb_pc || stb_inc)) |=>
      mar == $past(panel_sw)); // R9
endmodule

bind pg_addr_gen pgea_checker #(.WORD_W(WORD_W), .OFF_W(OFF_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .instr_word (instr_word),
  .prog_ctr   (prog_ctr),
  .panel_sw   (panel_sw),
  .ld_panel   (ld_panel),
  .stb_ea     (stb_ea),
  .stb_pc     (stb_pc),
  .stb_inc    (stb_inc),
  .mar        (mar)
);

// File: tb/pg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module pg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] instr_word = '0;
  logic [11:0] prog_ctr = '0;
  logic [11:0] panel_sw = '0;
  logic        ld_panel = 1'b0;
  logic        stb_ea = 1'b0;
  logic        stb_pc = 1'b0;
  logic        stb_inc = 1'b0;
  logic [11:0] mar;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pg_addr_gen dut_i (
    .clk(clk), .rst(rst), .instr_word(instr_word), .prog_ctr(prog_ctr),
    .panel_sw(panel_sw), .ld_panel(ld_panel), .stb_ea(stb_ea),
    .stb_pc(stb_pc), .stb_inc(stb_inc), .mar(mar)
  );

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: mar=%o expected %o", req, got, exp);
    end
  endtask

  // Apply one cycle of strobes; result is visible after the next rising edge.
  task automatic cycle(input logic p, input logic e, input logic c, input logic i);
    @(negedge clk);
    ld_panel = p; stb_ea = e; stb_pc = c; stb_inc = i;
    @(posedge clk);
    #1;
    ld_panel = 1'b0; stb_ea = 1'b0; stb_pc = 1'b0; stb_inc = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; panel_sw = 12'o5555;
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    check("R1", mar, 12'o0000);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_zero_page;
    logic [11:0] pcs [3] = '{12'o0000, 12'o5555, 12'o7777};
    foreach (pcs[k]) begin
      @(negedge clk); instr_word = 12'o7042; prog_ctr = pcs[k];
      cycle(1'b0, 1'b1, 1'b0, 1'b0);
      check("R2", mar, 12'o0042);
    end
    @(negedge clk); instr_word = 12'o0177; prog_ctr = 12'o7777;
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    check("R2", mar, 12'o0177);
  endtask

  task automatic t_cur_page;
    @(negedge clk); instr_word = 12'o7242; prog_ctr = 12'o7777;
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    check("R3", mar, 12'o7642);
    @(negedge clk); prog_ctr = 12'o1234;
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    check("R3", mar, 12'o1242);
    @(negedge clk); prog_ctr = 12'o0177;
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    check("R3", mar, 12'o0042);
  endtask

  task automatic t_opcode_ignored;
    @(negedge clk); instr_word = 12'o0042; prog_ctr = 12'o6543;
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", mar, 12'o0042);
    @(negedge clk); instr_word = 12'o5265;
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    check("R4", mar, 12'o6465);
  endtask

  task automatic t_pc_load;
    @(negedge clk); prog_ctr = 12'o3127;
    cycle(1'b0, 1'b0, 1'b1, 1'b0);
    check("R5", mar, 12'o3127);
  endtask

  task automatic t_panel_load;
    @(negedge clk); panel_sw = 12'o4321;
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", mar, 12'o4321);
  endtask

  task automatic t_increment;
    @(negedge clk); panel_sw = 12'o7776;
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7", mar, 12'o7777);
    cycle(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7", mar, 12'o0000);
  endtask

  task automatic t_hold;
    @(negedge clk); panel_sw = 12'o2525;
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); panel_sw = 12'o7070; prog_ctr = 12'o1111; instr_word = 12'o7377;
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", mar, 12'o2525);
  endtask

  task automatic t_priority;
    @(negedge clk); panel_sw = 12'o1357; prog_ctr = 12'o7600; instr_word = 12'o7215;
    cycle(1'b1, 1'b1, 1'b1, 1'b1);
    check("R9", mar, 12'o1357);
    cycle(1'b0, 1'b1, 1'b1, 1'b1);
    check("R9", mar, 12'o7615);
    cycle(1'b0, 1'b0, 1'b1, 1'b1);
    check("R9", mar, 12'o7600);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_zero_page();
    t_cur_page();
    t_opcode_ignored();
    t_pc_load();
    t_panel_load();
    t_increment();
    t_hold();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule